// File: doc/BRIEF.md
# Two-Wire Wiper Register Slave

This block is the two-wire serial slave that sets and reports the wiper position of a digital potentiometer. The block oversamples the bus clock and data lines with the system clock. It detects START and STOP conditions and compares each address byte against its own 7-bit address. On a match it acknowledges by pulling SDA low. SDA is open-drain: the block only ever asks the pad to pull the line low.

A write transfer has three bytes: the address byte, an instruction byte and a data byte. The instruction byte can ask for a plain load, a jump to midscale, or shutdown. A read transfer returns the stored wiper code, MSB first, for as long as the master keeps acknowledging.

The wiper code and the shutdown flag leave the block as registered outputs for the analog section.

Top module: `wiper_i2c_slave`

## Requirements
- R1: After reset the wiper code is 0x80, the shutdown flag is 0 and SDA is not driven.
- R2: An address byte whose upper six bits are 010110 and whose seventh bit equals `addr_sel` is acknowledged: SDA is held low during the ninth SCL clock. Bit 0 of the address byte selects the direction, 0 for write and 1 for read.
- R3: An address byte that does not match gets no acknowledge. The block then leaves SDA released and changes no state until the next START.
- R4: In a write, the instruction byte and the data byte are each acknowledged. With instruction bits 6 and 5 both clear, the data byte becomes the wiper code. The wiper code only ever changes while SCL is low.
- R5: With instruction bit 6 set and bit 5 clear, the wiper code becomes 0x80 and the data byte is ignored.
- R6: With instruction bit 5 set, the shutdown flag is set and the wiper code keeps its value. A later write with bit 5 clear clears the flag and loads the code again.
- R7: A read returns the wiper code MSB first. SDA changes only while SCL is low. Each master acknowledge starts another copy of the byte.
- R8: After the master does not acknowledge a read byte, SDA stays released until the next START.
- R9: A STOP condition (SDA rising while SCL is high) returns the block to idle. A write that is cut short before its data byte completes leaves the wiper code unchanged.
- R10: A repeated START restarts address decoding, so a write header can be followed directly by a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Lowest slave address bit |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| wiper_code | output | 8 | Stored wiper position |
| shutdown | output | 1 | Shutdown flag |

## Verification
Each bus line passes through a two-stage synchronizer and an edge register, and then the control register updates. As a result, `sda_oe` responds to an SCL edge on the third system clock edge after that edge. The wiper code and the flag follow one clock later than the acknowledge setup of the data byte. The bench holds each SCL phase for 20 system clocks and reads SDA in the middle of the high phase, well after any response is due. It reads `wiper_code` and `shutdown` after the STOP condition, when every update has settled.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_INSTR,
    ST_DATA,
    ST_ACK,
    ST_READ,
    ST_RACK,
    ST_IGNORE
  } slv_state_t;
endpackage

// File: rtl/wiper_bus_sync.sv
module wiper_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  localparam int LINES = 2;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] synced;
  logic             scl_s, scl_p, sda_p;

  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  assign scl_s = synced[1];
  assign sda_s = synced[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_s;
      sda_p <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_p;
  assign scl_fall = ~scl_s & scl_p;
  assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/wiper_slave_fsm.sv
module wiper_slave_fsm
  import wiper_pkg::*;
#(
  parameter int          W        = 8,
  parameter logic [5:0]  ADDR_HI  = 6'b010110,
  parameter int          MID_BIT  = 6,
  parameter int          SHDN_BIT = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sda_s,
  input  logic         scl_rise,
  input  logic         scl_fall,
  input  logic         start_ev,
  input  logic         stop_ev,
  input  logic         addr_sel,
  input  logic [W-1:0] rd_data,
  output logic         sda_oe,
  output logic         wr_en,
  output logic         wr_mid,
  output logic         wr_shdn,
  output logic [W-1:0] wr_data
);
  localparam int CNT_W = $clog2(W + 1);

  slv_state_t       state, ack_next;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0]     rx_sh, tx_sh;
  logic             more;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      ack_next <= ST_IDLE;
      cnt      <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      more     <= 1'b0;
      sda_oe   <= 1'b0;
      wr_en    <= 1'b0;
      wr_mid   <= 1'b0;
      wr_shdn  <= 1'b0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_ev) begin
        state  <= ST_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_ev) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_INSTR, ST_DATA: begin
            if (scl_rise && cnt != CNT_W'(W)) begin
              rx_sh <= {rx_sh[W-2:0], sda_s};
              cnt   <= cnt + CNT_W'(1);
            end else if (scl_fall && cnt == CNT_W'(W)) begin
              if (state == ST_ADDR) begin
                if (rx_sh[W-1:1] == {ADDR_HI, addr_sel}) begin
                  sda_oe   <= 1'b1;
                  state    <= ST_ACK;
                  ack_next <= rx_sh[0] ? ST_READ : ST_INSTR;
                end else begin
                  state <= ST_IGNORE;
                end
              end else if (state == ST_INSTR) begin
                wr_mid   <= rx_sh[MID_BIT];
                wr_shdn  <= rx_sh[SHDN_BIT];
                sda_oe   <= 1'b1;
                state    <= ST_ACK;
                ack_next <= ST_DATA;
              end else begin
                wr_en    <= 1'b1;
                wr_data  <= rx_sh;
                sda_oe   <= 1'b1;
                state    <= ST_ACK;
                ack_next <= ST_INSTR;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt   <= '0;
              state <= ack_next;
              if (ack_next == ST_READ) begin
                tx_sh  <= rd_data << 1;
                sda_oe <= ~rd_data[W-1];
              end else begin
                sda_oe <= 1'b0;
              end
            end
          end
          ST_READ: begin
            if (scl_fall) begin
              if (cnt == CNT_W'(W - 1)) begin
                sda_oe <= 1'b0;
                state  <= ST_RACK;
              end else begin
                cnt    <= cnt + CNT_W'(1);
                sda_oe <= ~tx_sh[W-1];
                tx_sh  <= tx_sh << 1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              more <= ~sda_s;
            end else if (scl_fall) begin
              if (more) begin
                state  <= ST_READ;
                cnt    <= '0;
                tx_sh  <= rd_data << 1;
                sda_oe <= ~rd_data[W-1];
              end else begin
                state <= ST_IGNORE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/wiper_store.sv
module wiper_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic         wr_mid,
  input  logic         wr_shdn,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] wiper_code,
  output logic         shutdown
);
  localparam logic [W-1:0] MIDSCALE = W'(1) << (W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      wiper_code <= MIDSCALE;
      shutdown   <= 1'b0;
    end else if (wr_en) begin
      shutdown <= wr_shdn;
      if (!wr_shdn) wiper_code <= wr_mid ? MIDSCALE : wr_data;
    end
  end
endmodule

// File: rtl/wiper_i2c_slave.sv
module wiper_i2c_slave #(
  parameter int         W           = 8,
  parameter logic [5:0] ADDR_HI     = 6'b010110,
  parameter int         SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         scl_i,
  input  logic         sda_i,
  input  logic         addr_sel,
  output logic         sda_oe,
  output logic [W-1:0] wiper_code,
  output logic         shutdown
);
  logic         sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic         wr_en, wr_mid, wr_shdn;
  logic [W-1:0] wr_data;

  wiper_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  wiper_slave_fsm #(.W(W), .ADDR_HI(ADDR_HI)) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .addr_sel(addr_sel), .rd_data(wiper_code), .sda_oe(sda_oe),
    .wr_en(wr_en), .wr_mid(wr_mid), .wr_shdn(wr_shdn), .wr_data(wr_data)
  );

  wiper_store #(.W(W)) u_store (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_mid(wr_mid),
    .wr_shdn(wr_shdn), .wr_data(wr_data),
    .wiper_code(wiper_code), .shutdown(shutdown)
  );
endmodule

// File: rtl/wiper_slave_chk.sv
module wiper_slave_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         scl_i,
  input logic         sda_oe,
  input logic [W-1:0] wiper_code,
  input logic         shutdown
);
  localparam logic [W-1:0] MIDSCALE = W'(1) << (W - 1);

  a_r1_reset_state: assert property (@(posedge clk)
    (!rst && $past(rst)) |-> (wiper_code == MIDSCALE && !shutdown && !sda_oe));

  a_r7_sda_moves_low: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  a_r4_code_moves_low: assert property (@(posedge clk) disable iff (rst)
    (wiper_code != $past(wiper_code)) |-> !scl_i);

  a_r6_shutdown_keeps_code: assert property (@(posedge clk) disable iff (rst)
    $rose(shutdown) |-> $stable(wiper_code));
endmodule

bind wiper_i2c_slave wiper_slave_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe),
  .wiper_code(wiper_code), .shutdown(shutdown)
);

// File: tb/tb_wiper_i2c_slave.sv
module tb_wiper_i2c_slave;
  localparam int Q = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       addr_sel = 1'b0;
  logic       sda_oe, shutdown;
  logic [7:0] wiper_code;
  wire        sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int errors = 0;

  typedef struct { string req; logic [7:0] val; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  wiper_i2c_slave dut (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
    .addr_sel(addr_sel), .sda_oe(sda_oe),
    .wiper_code(wiper_code), .shutdown(shutdown)
  );

  task automatic push(input string req, input logic [7:0] val);
    exp_t e;
    e.req = req;
    e.val = val;
    exp_q.push_back(e);
  endtask

  // Monitor side of the scoreboard: pops the oldest expectation.
  task automatic observe(input logic [7:0] act);
    exp_t e;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL scoreboard empty: actual %h expected none", act);
    end else begin
      e = exp_q.pop_front();
      if (act !== e.val) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", e.req, act, e.val);
      end
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q);
    scl_m = 1'b1; hold(Q);
    sda_m = 1'b1; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(Q);
      scl_m = 1'b1; hold(Q);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; hold(Q);
    scl_m = 1'b1; hold(Q / 2);
    ack = ~sda_bus;
    hold(Q / 2);
    scl_m = 1'b0;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      hold(Q);
      scl_m = 1'b1; hold(Q / 2);
      b[i] = sda_bus;
      hold(Q / 2);
      scl_m = 1'b0;
    end
    sda_m = ~m_ack; hold(Q);
    scl_m = 1'b1; hold(Q);
    scl_m = 1'b0; hold(2);
    sda_m = 1'b1;
  endtask

  task automatic wr_xfer(input logic [7:0] adr, input logic [7:0] ins,
                         input logic [7:0] dat, input logic exp_ack,
                         input string req);
    logic a;
    bus_start();
    push(req, {7'd0, exp_ack}); send_byte(adr, a); observe({7'd0, a});
    push(req, {7'd0, exp_ack}); send_byte(ins, a); observe({7'd0, a});
    push(req, {7'd0, exp_ack}); send_byte(dat, a); observe({7'd0, a});
    bus_stop();
    hold(4);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    logic       a;
    logic [7:0] rb;
    int         lows;
    hold(5);
    rst = 1'b0;
    hold(3);

    // R1 reset state
    push("R1 wiper", 8'h80);   observe(wiper_code);
    push("R1 shutdown", 8'h00); observe({7'd0, shutdown});
    push("R1 sda_oe", 8'h00);  observe({7'd0, sda_oe});

    // R2 R4 plain write, address 0x58 with addr_sel = 0
    wr_xfer(8'h58, 8'h00, 8'h3C, 1'b1, "R2 R4 ack");
    push("R4 wiper load", 8'h3C); observe(wiper_code);

    // R7 R8 read with master NACK, then clock on and watch SDA
    bus_start();
    push("R2 read ack", 8'h01); send_byte(8'h59, a); observe({7'd0, a});
    push("R7 read byte", 8'h3C); recv_byte(1'b0, rb); observe(rb);
    lows = 0;
    for (int i = 0; i < 9; i++) begin
      hold(Q); scl_m = 1'b1; hold(Q / 2);
      if (!sda_bus) lows++;
      hold(Q / 2); scl_m = 1'b0;
    end
    push("R8 released after nack", 8'h00); observe(8'(lows));
    bus_stop();

    // R3 wrong address: no acks, no change
    wr_xfer(8'h5A, 8'h00, 8'h11, 1'b0, "R3 no ack");
    push("R3 wiper kept", 8'h3C); observe(wiper_code);

    // R5 midscale ignores data
    wr_xfer(8'h58, 8'h40, 8'hAA, 1'b1, "R5 ack");
    push("R5 midscale", 8'h80); observe(wiper_code);

    // R6 shutdown keeps code, later write clears it
    wr_xfer(8'h58, 8'h00, 8'hC3, 1'b1, "R4 ack");
    push("R4 wiper load", 8'hC3); observe(wiper_code);
    wr_xfer(8'h58, 8'h60, 8'h05, 1'b1, "R6 ack");
    push("R6 shutdown set", 8'h01); observe({7'd0, shutdown});
    push("R6 code kept", 8'hC3); observe(wiper_code);
    wr_xfer(8'h58, 8'h00, 8'h07, 1'b1, "R6 ack");
    push("R6 shutdown clear", 8'h00); observe({7'd0, shutdown});
    push("R6 code loaded", 8'h07); observe(wiper_code);

    // R9 write cut by STOP before data completes
    bus_start();
    push("R9 ack", 8'h01); send_byte(8'h58, a); observe({7'd0, a});
    push("R9 ack", 8'h01); send_byte(8'h00, a); observe({7'd0, a});
    for (int i = 7; i >= 4; i--) begin
      sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(Q); scl_m = 1'b0;
    end
    bus_stop(); hold(4);
    push("R9 wiper kept", 8'h07); observe(wiper_code);
    push("R9 sda released", 8'h00); observe({7'd0, sda_oe});

    // R10 repeated start into a two-byte read
    bus_start();
    push("R10 ack", 8'h01); send_byte(8'h58, a); observe({7'd0, a});
    push("R10 ack", 8'h01); send_byte(8'h00, a); observe({7'd0, a});
    bus_start();
    push("R10 read ack", 8'h01); send_byte(8'h59, a); observe({7'd0, a});
    push("R7 first byte", 8'h07); recv_byte(1'b1, rb); observe(rb);
    push("R7 second byte", 8'h07); recv_byte(1'b0, rb); observe(rb);
    bus_stop(); hold(4);
    push("R10 wiper kept", 8'h07); observe(wiper_code);

    // R2 R3 address select pin changes the matching address
    addr_sel = 1'b1;
    hold(4);
    wr_xfer(8'h5A, 8'h00, 8'h99, 1'b1, "R2 sel ack");
    push("R2 sel wiper", 8'h99); observe(wiper_code);
    wr_xfer(8'h58, 8'h00, 8'h22, 1'b0, "R3 old addr");
    push("R3 wiper kept", 8'h99); observe(wiper_code);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule